// File: doc/BRIEF.md
# Algorithmic Noise Tolerance Result Selector

This block guards an arithmetic result against timing errors that appear when the supply is scaled below the level the critical path needs. Each accepted operand pair is multiplied twice, side by side. The main path forms the full-precision product. The replica path multiplies only the upper nibble of each operand, which gives a much shorter carry chain. The replica product is then shifted up so that it has the same scale as the main product. Timing faults tend to land in the high-order bits of the main product, so a large gap between the two products points to a corrupted main result.

When the absolute gap is strictly below a programmable threshold, the main product goes out. When the gap is equal to or above the threshold, the replica estimate goes out instead, together with a sideband flag, a one-cycle event pulse and a step of a saturating event counter. A test input adds a chosen error word to the main product. This lets a bench place the gap on either side of the threshold without any voltage control. Operands enter on a valid/ready stream, and results leave on a valid/ready stream through a single output register. A beat whose result is not taken keeps its values and stalls the input.

Top module: `ant_selector`

## Requirements
- R1: After reset, out_valid, err_pulse and err_count are all zero and in_ready is one.
- R2: The main value is (in_a * in_b + inj_err) modulo 2^16, with operands taken as unsigned. When |main − replica| < thr, out_result equals the main value and out_replica is 0.
- R3: The replica value is (in_a[7:4] * in_b[7:4]) shifted left by 8. When |main − replica| ≥ thr, including equality, out_result equals the replica value, so its low 8 bits are zero.
- R4: out_replica travels with each output beat. It is 1 exactly when that beat carries the replica value.
- R5: err_pulse is high for exactly one cycle, the first cycle a replica-carrying beat is presented, and never while a beat that carries the main value is presented.
- R6: err_count increases by one for every accepted beat that selects the replica. It is visible together with that beat, and it holds at 255 once it reaches 255.
- R7: While out_valid is high and out_ready is low, out_result, out_replica and err_count stay stable, and in_ready is low.
- R8: An input beat is accepted when in_valid and in_ready are both high, and its result is presented with out_valid high on the following cycle. in_ready is high whenever the output register is empty or is being drained.
- R9: A threshold of zero always selects the replica, even when both products are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can accept an operand beat |
| in_a | input | 8 | First unsigned operand |
| in_b | input | 8 | Second unsigned operand |
| thr | input | 16 | Gap threshold, sampled on acceptance |
| inj_err | input | 16 | Test error word added to the main product, zero in normal use |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result beat |
| out_result | output | 16 | Selected result |
| out_replica | output | 1 | Beat carries the replica estimate |
| err_pulse | output | 1 | One-cycle event for a replica selection |
| err_count | output | 8 | Saturating count of replica selections |

## Verification
The assertions assume that thr and inj_err count only at the acceptance edge, and that a downstream stall lasts as long as out_ready stays low. They do not constrain how the source drives in_valid. The stimulus changes every input only at falling clock edges. It sweeps all 65,536 operand pairs while thr and inj_err follow arithmetic patterns, so the gap lands on both sides of the threshold. Directed beats then set the gap exactly equal to the threshold and one above it, use a zero threshold, and force the main product to wrap below the replica. A single stall window presents a second beat while the first one is held.

// File: rtl/ant_pkg.sv
package ant_pkg;

  typedef enum logic {
    SRC_MAIN    = 1'b0,
    SRC_REPLICA = 1'b1
  } ant_src_e;

endpackage

// File: rtl/ant_main_path.sv
module ant_main_path #(
  parameter int DATA_W = 8,
  parameter int RES_W  = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [RES_W-1:0]  inject,
  output logic [RES_W-1:0]  main_res
);

  localparam int PAD_W = RES_W - DATA_W;

  logic [RES_W-1:0] wide_a;
  logic [RES_W-1:0] wide_b;
  logic [RES_W-1:0] product;

  assign wide_a   = {{PAD_W{1'b0}}, op_a};
  assign wide_b   = {{PAD_W{1'b0}}, op_b};
  assign product  = wide_a * wide_b;
  // test hook: an added error word stands in for a timing fault
  assign main_res = product + inject;

endmodule

// File: rtl/ant_replica_path.sv
module ant_replica_path #(
  parameter int DATA_W = 8,
  parameter int KEEP_W = 4,
  parameter int RES_W  = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [RES_W-1:0]  rep_res
);

  localparam int DROP_W  = DATA_W - KEEP_W;
  localparam int PROD_W  = 2 * KEEP_W;
  localparam int SHIFT_W = 2 * DROP_W;

  logic [KEEP_W-1:0] hi_a;
  logic [KEEP_W-1:0] hi_b;
  logic [PROD_W-1:0] hi_prod;

  assign hi_a    = op_a[DATA_W-1 -: KEEP_W];
  assign hi_b    = op_b[DATA_W-1 -: KEEP_W];
  assign hi_prod = {{KEEP_W{1'b0}}, hi_a} * {{KEEP_W{1'b0}}, hi_b};

  generate
    if (SHIFT_W > 0) begin : g_align
      assign rep_res = {hi_prod, {SHIFT_W{1'b0}}};
    end else begin : g_noalign
      assign rep_res = hi_prod;
    end
  endgenerate

endmodule

// File: rtl/ant_select.sv
module ant_select
  import ant_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic [RES_W-1:0] main_res,
  input  logic [RES_W-1:0] rep_res,
  input  logic [RES_W-1:0] thr,
  output ant_src_e         src,
  output logic [RES_W-1:0] chosen
);

  localparam int EXT_W = RES_W + 1;

  logic [EXT_W-1:0] fwd;
  logic [EXT_W-1:0] bwd;
  logic [RES_W-1:0] gap;

  assign fwd = {1'b0, main_res} - {1'b0, rep_res};
  assign bwd = {1'b0, rep_res} - {1'b0, main_res};
  assign gap = fwd[RES_W] ? bwd[RES_W-1:0] : fwd[RES_W-1:0];

  always_comb begin
    if (gap < thr) begin
      src    = SRC_MAIN;
      chosen = main_res;
    end else begin
      src    = SRC_REPLICA;
      chosen = rep_res;
    end
  end

endmodule

// File: rtl/ant_sat_counter.sv
module ant_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (bump && (count != TOP)) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/ant_selector.sv
module ant_selector
  import ant_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int KEEP_W = 4,
  parameter int CNT_W  = 8,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [RES_W-1:0]  thr,
  input  logic [RES_W-1:0]  inj_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RES_W-1:0]  out_result,
  output logic              out_replica,
  output logic              err_pulse,
  output logic [CNT_W-1:0]  err_count
);

  logic [RES_W-1:0] main_res;
  logic [RES_W-1:0] rep_res;
  logic [RES_W-1:0] chosen;
  ant_src_e         src;
  logic             take;
  logic             take_rep;

  ant_main_path #(.DATA_W(DATA_W), .RES_W(RES_W)) u_main (
    .op_a     (in_a),
    .op_b     (in_b),
    .inject   (inj_err),
    .main_res (main_res)
  );

  ant_replica_path #(.DATA_W(DATA_W), .KEEP_W(KEEP_W), .RES_W(RES_W)) u_rep (
    .op_a    (in_a),
    .op_b    (in_b),
    .rep_res (rep_res)
  );

  ant_select #(.RES_W(RES_W)) u_sel (
    .main_res (main_res),
    .rep_res  (rep_res),
    .thr      (thr),
    .src      (src),
    .chosen   (chosen)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign take_rep = take && (src == SRC_REPLICA);

  ant_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (take_rep),
    .count (err_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_replica <= 1'b0;
      err_pulse   <= 1'b0;
    end else begin
      err_pulse <= take_rep;
      if (take) begin
        out_valid   <= 1'b1;
        out_result  <= chosen;
        out_replica <= (src == SRC_REPLICA);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ant_selector_checker.sv
module ant_selector_checker #(
  parameter int RES_W  = 16,
  parameter int ZERO_W = 8,
  parameter int CNT_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [RES_W-1:0] out_result,
  input logic             out_replica,
  input logic             err_pulse,
  input logic [CNT_W-1:0] err_count
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assert_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
                                && $stable(out_replica) && $stable(err_count));

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_replica_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_replica |-> out_result[ZERO_W-1:0] == '0);

  assert_pulse_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> out_valid && out_replica);

  assert_pulse_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse && !out_ready |=> !err_pulse);

  assert_count_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> $stable(err_count));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_count == TOP |=> err_count == TOP);

endmodule

bind ant_selector ant_selector_checker #(
  .RES_W  (RES_W),
  .ZERO_W (2 * (DATA_W - KEEP_W)),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_replica (out_replica),
  .err_pulse   (err_pulse),
  .err_count   (err_count)
);

// File: tb/ant_selector_bench.sv
`timescale 1ns/1ps
module ant_selector_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_a = '0;
  logic [7:0]  in_b = '0;
  logic [15:0] thr = '0;
  logic [15:0] inj_err = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic        out_replica;
  logic        err_pulse;
  logic [7:0]  err_count;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ant_selector u_ant_selector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .thr(thr), .inj_err(inj_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_replica(out_replica), .err_pulse(err_pulse), .err_count(err_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int main_of(input int a, input int b, input int e);
    return (a * b + e) & 16'hFFFF;
  endfunction

  function automatic int rep_of(input int a, input int b);
    return ((a >> 4) * (b >> 4)) << 8;
  endfunction

  function automatic bit picks_rep(input int m, input int r, input int t);
    int g;
    g = (m >= r) ? (m - r) : (r - m);
    return g >= t;
  endfunction

  // drive one beat at the current falling edge, check it at the next one
  task automatic beat(input int a, input int b, input int t, input int e);
    int m, r, x;
    bit rp;
    m  = main_of(a, b, e);
    r  = rep_of(a, b);
    rp = picks_rep(m, r, t);
    x  = rp ? r : m;
    if (rp && exp_cnt < 255) exp_cnt++;
    in_a = a[7:0]; in_b = b[7:0]; thr = t[15:0]; inj_err = e[15:0];
    in_valid = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b1, "R8 out_valid", int'(out_valid), 1);
    if (rp) check(out_result == x[15:0], "R3 replica result", int'(out_result), x);
    else    check(out_result == x[15:0], "R2 main result", int'(out_result), x);
    check(out_replica == rp, "R4 sideband", int'(out_replica), int'(rp));
    check(err_pulse == rp, "R5 pulse", int'(err_pulse), int'(rp));
    check(int'(err_count) == exp_cnt, "R6 count", int'(err_count), exp_cnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(err_pulse == 1'b0, "R1 err_pulse", int'(err_pulse), 0);
    check(err_count == 8'd0, "R1 err_count", int'(err_count), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    // directed gap cases: 200*100 = 20000, replica 72<<8 = 18432, gap 1568
    beat(200, 100, 1568, 0);   // R3 equal to threshold -> replica
    beat(200, 100, 1569, 0);   // R2 one above gap -> main
    beat(0, 0, 0, 0);          // R9 zero threshold, equal products
    beat(255, 255, 0, 0);      // R9
    beat(16, 16, 1, 0);        // R2 exact replica, gap 0 < 1
    beat(17, 17, 100, 16'hFF00); // main wraps below replica
    beat(128, 128, 256, 256);  // R3 injected gap equals threshold
    beat(128, 128, 257, 256);  // R2

    // full operand sweep with patterned threshold and injection
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        beat(a, b, ((a ^ b) * 29) & 16'h1FFF, b[0] ? ((a & 7) << 9) : 0);
      end
    end

    // R9 and saturation: zero threshold always picks replica
    for (int k = 0; k < 260; k++) beat(k & 255, (k * 7) & 255, 0, 0);
    check(err_count == 8'd255, "R6 saturated", int'(err_count), 255);

    // back-pressure window (R7)
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 drained", int'(out_valid), 0);
    out_ready = 1'b0;
    in_a = 8'd200; in_b = 8'd100; thr = 16'd5000; inj_err = '0; in_valid = 1'b1;
    @(negedge clk);
    check(out_result == 16'd20000, "R2 stall beat", int'(out_result), 20000);
    held = int'(out_result);
    in_a = 8'd3; in_b = 8'd5; thr = 16'd1;
    check(in_ready == 1'b0, "R7 in_ready low", int'(in_ready), 0);
    @(negedge clk);
    check(int'(out_result) == held, "R7 held result", int'(out_result), held);
    check(out_valid == 1'b1, "R7 held valid", int'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    // 3*5 = 15, replica 0, gap 15 >= 1 -> replica 0
    check(out_result == 16'd0, "R3 after stall", int'(out_result), 0);
    check(out_replica == 1'b1, "R4 after stall", int'(out_replica), 1);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 empty", int'(out_valid), 0);
    check(err_pulse == 1'b0, "R5 no pulse idle", int'(err_pulse), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule